// File: doc/BRIEF.md
# Object Field Cache

This block is a small data cache that sits between a processor core and main memory and keeps the fields of heap objects. A lookup is addressed by an object reference together with a field index, not by a byte address. The cache is two-way set associative. The low bits of the reference select a set. Each line is tagged with the full reference and holds four field words. Each of those words has its own valid bit, so a line can be partly filled.

Both ways are compared against the reference at the same time. In parallel, the field index picks the valid bit to test in each way. The resulting one-hot match vector is encoded into a way number. The set, the way and the field index are then joined to form the address of the data array. Misses fetch only the requested field. Writes always go through to memory. Field indices of four and above do not use the cache and go straight to memory.

Top module: `obj_field_cache`

## Requirements
- R1: After reset `ready_o` is 1, `done_o` and `mem_req_o` are 0, and every line is empty, so the first read of any field reaches memory.
- R2: A read whose reference matches a line tag and whose field valid bit is set completes with `done_o` two rising edges after acceptance. It returns the cached word and issues no memory request.
- R3: A read miss issues exactly one memory read carrying the request's reference and field index, and it returns `mem_rdata_i`. The fetched field then hits on later reads.
- R4: A miss fills only the requested field. Other fields of the same reference keep missing until they are fetched or written.
- R5: The set is the low SET_W bits of the reference. Two references that map to the same set can both be resident, one per way.
- R6: On an allocating miss the victim is an empty way (way 0 first). If both ways are occupied, the victim is the least recently used way of the set. A hit, a fill or a write hit marks the way it used as most recent. An evicted reference misses afterwards.
- R7: Every write issues a memory write with `mem_we_o`=1. If the reference's line is present, the cached word is updated and the field's valid bit is set, so a later read hits and returns the written value.
- R8: A write to a reference with no resident line allocates nothing. A later read of that field still misses.
- R9: A request with a field index of 4 or more always goes to memory and never changes the cache contents.
- R10: One request is in flight at a time. `ready_o` is 0 from acceptance until completion. `mem_req_o` stays high with a stable address until `mem_ack_i`, and `done_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when `ready_o` is 1 |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_ref_i | input | REF_W | Object reference |
| req_idx_i | input | IDX_W | Field index |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result, valid with `done_o` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_ref_o | output | REF_W | Memory access reference |
| mem_idx_o | output | IDX_W | Memory access field index |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory completion, one cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid with `mem_ack_i` |

## Verification
The hardest situation to reach is a replacement decided by recency. It needs a set holding two lines, one of them touched again by a hit, and then a third reference in the same set. It must be followed by a re-read that shows the correct line was evicted while the partly valid survivor still holds only its own fields. The stimulus reaches it with a directed sequence of three references that share set 0. After that, random traffic draws from a pool of eight references crowded into four sets, with field indices 0 to 5 and about one write in four. Evictions, partial lines, write hits and bypasses therefore recur constantly. Every access is checked against a bench model of tags, per-field valid bits and recency. Memory answers with random latency.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int unsigned WAYS   = 2;
  localparam int unsigned FIELDS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MEM  = 2'd2
  } ofc_state_e;
endpackage

// File: rtl/ofc_tag_match.sv
module ofc_tag_match #(
  parameter int unsigned REF_W = 16,
  parameter int unsigned WAYS  = 2
) (
  input  logic [WAYS*REF_W-1:0] tags_i,
  input  logic [WAYS-1:0]       present_i,
  input  logic [REF_W-1:0]      ref_i,
  output logic [WAYS-1:0]       match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match_o[w] = present_i[w] && (tags_i[w*REF_W +: REF_W] == ref_i);
  end
endmodule

// File: rtl/ofc_hit_enc.sv
module ofc_hit_enc #(
  parameter int unsigned N = 2,
  parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/obj_field_cache.sv
module obj_field_cache
  import ofc_pkg::*;
#(
  parameter int unsigned REF_W  = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SET_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [REF_W-1:0]  req_ref_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [REF_W-1:0]  mem_ref_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned SETS  = 1 << SET_W;
  localparam int unsigned FLD_W = $clog2(FIELDS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned AW    = SET_W + WAY_W + FLD_W;
  localparam int unsigned DEPTH = 1 << AW;

  ofc_state_e state_q;
  logic              we_q, done_q;
  logic [REF_W-1:0]  ref_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic [REF_W-1:0]  tag_q [SETS][WAYS];
  logic [FIELDS-1:0] fv_q  [SETS][WAYS];
  logic [WAY_W-1:0]  lru_q [SETS];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [SET_W-1:0]       set_s;
  logic [FLD_W-1:0]       fld_s;
  logic                   cacheable;
  logic [WAYS*REF_W-1:0]  way_tags;
  logic [WAYS-1:0]        present, match_vec, fld_ok, hit_vec;
  logic [WAY_W-1:0]       match_way, victim, fill_way;
  logic                   line_hit, hit;

  assign set_s     = ref_q[SET_W-1:0];
  assign fld_s     = idx_q[FLD_W-1:0];
  assign cacheable = (idx_q >> FLD_W) == '0;

  for (genvar w = 0; w < WAYS; w++) begin : g_sel
    assign way_tags[w*REF_W +: REF_W] = tag_q[set_s][w];
    assign present[w] = |fv_q[set_s][w];
    assign fld_ok[w]  = fv_q[set_s][w][fld_s];
  end

  ofc_tag_match #(.REF_W(REF_W), .WAYS(WAYS)) u_match (
    .tags_i   (way_tags),
    .present_i(present),
    .ref_i    (ref_q),
    .match_o  (match_vec)
  );

  ofc_hit_enc #(.N(WAYS), .W(WAY_W)) u_enc (
    .vec_i(match_vec),
    .idx_o(match_way)
  );

  assign hit_vec  = match_vec & fld_ok & {WAYS{cacheable}};
  assign hit      = |hit_vec;
  assign line_hit = |match_vec;

  // empty way first (lowest), else least recently used
  always_comb begin
    victim = lru_q[set_s];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!present[w]) victim = WAY_W'(w);
    end
  end
  assign fill_way = line_hit ? match_way : victim;

  // data array write port
  logic              dwe;
  logic [AW-1:0]     dwa;
  logic [DATA_W-1:0] dwd;

  always_comb begin
    dwe = 1'b0;
    dwa = {set_s, fill_way, fld_s};
    dwd = we_q ? wdata_q : mem_rdata_i;
    if (state_q == ST_MEM && mem_ack_i && cacheable)
      dwe = we_q ? line_hit : 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (dwe) data_q[dwa] <= dwd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      ref_q   <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          fv_q[s][w]  <= '0;
        end
      end
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          we_q    <= req_we_i;
          ref_q   <= req_ref_i;
          idx_q   <= req_idx_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!we_q && hit) begin
            rdata_q       <= data_q[{set_s, match_way, fld_s}];
            lru_q[set_s]  <= ~match_way;
            done_q        <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (!we_q) rdata_q <= mem_rdata_i;
          if (cacheable && (line_hit || !we_q)) begin
            lru_q[set_s] <= ~fill_way;
            if (line_hit) begin
              fv_q[set_s][fill_way][fld_s] <= 1'b1;
            end else begin
              tag_q[set_s][fill_way] <= ref_q;
              fv_q[set_s][fill_way]  <= FIELDS'(1) << fld_s;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = state_q == ST_IDLE;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = state_q == ST_MEM;
  assign mem_we_o    = we_q;
  assign mem_ref_o   = ref_q;
  assign mem_idx_o   = idx_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/ofc_checker.sv
module ofc_checker #(
  parameter int unsigned REF_W  = 16,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned FIELDS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [REF_W-1:0] mem_ref_o,
  input logic [IDX_W-1:0] mem_idx_o,
  input logic [WAYS-1:0]  match_vec
);
  // R5: a reference is resident in at most one way of its set
  p_single_way_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_ref_o)
      && $stable(mem_idx_o) && $stable(mem_we_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o && !mem_req_o);

  p_write_through_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mem_we_o |-> $past(mem_req_o && mem_ack_i));

  p_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mem_idx_o >= IDX_W'(FIELDS)) |-> $past(mem_req_o && mem_ack_i));
endmodule

bind obj_field_cache ofc_checker #(
  .REF_W (REF_W),
  .IDX_W (IDX_W),
  .WAYS  (ofc_pkg::WAYS),
  .FIELDS(ofc_pkg::FIELDS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .mem_req_o(mem_req_o),
  .mem_we_o (mem_we_o),
  .mem_ack_i(mem_ack_i),
  .mem_ref_o(mem_ref_o),
  .mem_idx_o(mem_idx_o),
  .match_vec(match_vec)
);

// File: tb/sim_obj_field_cache.sv
`timescale 1ns/100ps
module sim_obj_field_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_ref = '0;
  logic [7:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic ready, done, mem_req, mem_we;
  logic [31:0] rdata, mem_wdata;
  logic [15:0] mem_ref;
  logic [7:0]  mem_idx;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0, checks = 0, cycles = 0;
  int mem_cnt = 0, delay_cnt = 0;
  logic [15:0] last_ref;
  logic [7:0]  last_idx;
  logic        last_we;
  logic [31:0] mem_m [int];

  logic [15:0] m_tag [4][2];
  logic [3:0]  m_fv  [4][2];
  logic        m_lru [4];

  always #2.5 clk = ~clk;

  obj_field_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_ref_i(req_ref),
    .req_idx_i(req_idx), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_ref_o(mem_ref),
    .mem_idx_o(mem_idx), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_val(logic [15:0] r, logic [7:0] i);
    int key = int'({r, i});
    if (mem_m.exists(key)) return mem_m[key];
    return {r, i, 8'hA5};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (delay_cnt == 0) begin
          last_ref = mem_ref; last_idx = mem_idx; last_we = mem_we;
          if (mem_we) mem_m[int'({mem_ref, mem_idx})] = mem_wdata;
          else mem_rdata = mem_val(mem_ref, mem_idx);
          mem_ack = 1'b1;
          mem_cnt++;
          delay_cnt = $urandom_range(0, 3);
        end else delay_cnt--;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", 32'(cycles), 32'd150000);
        finish_run();
      end
    end
  end

  task automatic op(input logic we, input logic [15:0] r, input logic [7:0] i,
                    input logic [31:0] wd, input string tag_o);
    int s = int'(r[1:0]);
    int f = int'(i[1:0]);
    int m = -1;
    int v, lat, cnt0;
    bit cach = (i < 8'd4);
    bit exp_hit, used;
    logic [31:0] exp_d;
    string tg;
    if (cach) for (int w = 0; w < 2; w++)
      if (m_fv[s][w] != 0 && m_tag[s][w] == r) m = w;
    exp_hit = cach && !we && m >= 0 && m_fv[s][m][f];
    exp_d = mem_val(r, i);
    if (!cach) tg = "R9";
    else if (we) tg = (m >= 0) ? "R7" : "R8";
    else if (exp_hit) tg = "R2";
    else if (m >= 0) tg = "R4";
    else if (m_fv[s][0] != 0 && m_fv[s][1] != 0) tg = "R6";
    else tg = "R3";
    if (tag_o != "") tg = tag_o;

    @(negedge clk);
    check(ready == 1'b1, "R10 ready before request", 32'(ready), 32'd1);
    cnt0 = mem_cnt;
    req_valid = 1'b1; req_we = we; req_ref = r; req_idx = i; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    check(ready == 1'b0, "R10 busy after accept", 32'(ready), 32'd0);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(done == 1'b1, {tg, " completion"}, 32'(done), 32'd1);
    used = (mem_cnt != cnt0);
    check(used == !exp_hit, {tg, " memory used"}, 32'(used), 32'(!exp_hit));
    if (exp_hit) check(lat == 2, "R2 hit latency", 32'(lat), 32'd2);
    if (used) begin
      check(last_ref == r && last_idx == i && last_we == we,
            {tg, " memory address"}, {last_ref, last_idx, 7'd0, last_we},
            {r, i, 7'd0, we});
      check(mem_cnt - cnt0 == 1, {tg, " single access"}, 32'(mem_cnt - cnt0), 32'd1);
    end
    if (!we) check(rdata == exp_d, {tg, " read data"}, rdata, exp_d);

    // model update
    if (cach) begin
      if (we) begin
        if (m >= 0) begin m_fv[s][m][f] = 1'b1; m_lru[s] = (m == 0); end
      end else if (m >= 0) begin
        m_fv[s][m][f] = 1'b1; m_lru[s] = (m == 0);
      end else begin
        v = (m_fv[s][0] == 0) ? 0 : (m_fv[s][1] == 0) ? 1 : int'(m_lru[s]);
        m_tag[s][v] = r; m_fv[s][v] = 4'b1 << f; m_lru[s] = (v == 0);
      end
    end
  endtask

  localparam logic [15:0] POOL [8] = '{16'h0010, 16'h0020, 16'h0030, 16'h0011,
                                       16'h0021, 16'h0012, 16'h0013, 16'h0040};

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin m_tag[s][w] = '0; m_fv[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
          {29'd0, ready, done, mem_req}, 32'h4);
    rst_n = 1'b1;

    op(0, 16'h0010, 8'd1, '0, "R1");        // empty cache misses
    op(0, 16'h0010, 8'd1, '0, "R2");        // hit
    op(0, 16'h0010, 8'd2, '0, "R4");        // partial line miss
    op(0, 16'h0010, 8'd0, '0, "R4");
    op(0, 16'h0011, 8'd0, '0, "R5");        // other set
    op(0, 16'h0020, 8'd3, '0, "R5");        // same set, second way
    op(0, 16'h0010, 8'd1, '0, "R5");        // both resident
    op(0, 16'h0020, 8'd3, '0, "R5");
    op(0, 16'h0010, 8'd2, '0, "R6");        // 0x0020 becomes LRU
    op(0, 16'h0030, 8'd0, '0, "R6");        // evicts 0x0020
    op(0, 16'h0010, 8'd1, '0, "R6");        // survivor still hits
    op(0, 16'h0020, 8'd3, '0, "R6");        // evicted ref misses
    op(1, 16'h0010, 8'd3, 32'hDEAD_BEEF, "R7"); // write hit line present
    op(0, 16'h0010, 8'd3, '0, "R7");        // now hits with written data
    op(1, 16'h0050, 8'd1, 32'h1234_5678, "R8"); // absent line
    op(0, 16'h0050, 8'd1, '0, "R8");        // still misses
    op(0, 16'h0010, 8'd4, '0, "R9");        // bypass
    op(1, 16'h0010, 8'd5, 32'hCAFE_0001, "R9");
    op(0, 16'h0010, 8'd5, '0, "R9");
    op(0, 16'h0010, 8'd1, '0, "R9");        // cache unaffected

    for (int n = 0; n < 600; n++) begin
      logic [15:0] r = POOL[$urandom_range(0, 7)];
      logic [7:0]  i = 8'($urandom_range(0, 5));
      logic        we = ($urandom_range(0, 3) == 0);
      op(we, r, i, $urandom, "");
    end
    finish_run();
  end
endmodule